// File: doc/BRIEF.md
# UART Register Front End

This block sits between a simple register bus and the byte-level side of a UART. A master reaches four 32-bit words through a valid/write/address/data port. Address bits [3:2] select the word: 0 is receive data, 1 is transmit data, 2 is status and 3 is control. Read data is combinational in the access cycle. All state changes take effect at the clock edge that ends the access.

On the line side, bytes arrive on a ready/valid stream and are kept in a circular receive queue. The queue is `DEPTH` entries deep, 8 by default. The bus drains it by reading the receive-data word. A write to the transmit-data word sends its low byte out as a one-cycle strobe. Error flags from the serialiser (overrun, framing, parity) pass straight into the status word.

An interrupt-pending flag is set by receive data and by transmit writes. A status read clears it. It drives the interrupt output only while the enable bit in the control word is set.

Top module: `uart_fe`

## Requirements
- R1: The word is selected by address bits [3:2]: 0 receive data, 1 transmit data, 2 status, 3 control. The control word reads back the full 32-bit value last written to it. The transmit word reads back the full 32-bit value last written to it.
- R2: Received bytes are read out in arrival order from an 8-entry circular queue, including after the write position wraps. A read returns the byte in bits [7:0], with bits [31:8] zero.
- R3: A read of the receive-data word removes the oldest byte when the queue is nonempty. When the queue is empty the read changes no state.
- R4: `rx_ready` is low exactly while 8 bytes are held. A byte offered while full is discarded and never read out.
- R5: The status word has the following fields:
  - bit 0: queue nonempty
  - bit 1: queue full
  - bit 2: transmit empty, always 1
  - bit 3: transmit full, always 0
  - bit 4: interrupt pending
  - bits 5, 6, 7: `line_err[0]`, `line_err[1]`, `line_err[2]` (overrun, framing, parity)
  - bits [31:8]: zero
- R6: A control write with bit 1 set empties the queue. It resets the write position, takes priority over a byte arriving in the same cycle, and that byte is dropped.
- R7: The pending flag is 1 after any cycle that ends with the queue nonempty. It is also 1 after any cycle with a transmit-data write.
- R8: A status read clears the pending flag, unless the queue is nonempty at the end of that cycle. The status value returned in that cycle still shows the flag before it is cleared.
- R9: `irq` is high exactly when the pending flag is 1 and control bit 4 is 1.
- R10: Writes to the status word have no effect on any state.
- R11: A transmit-data write pulses `tx_strobe` for exactly one cycle, in the cycle after the write. `tx_data` carries bits [7:0] of the written value.
- R12: After reset the status word reads 0x04. Control reads 0, transmit reads 0, `irq` is 0 and `rx_ready` is 1.
- R13: A byte accepted in the same cycle as a receive-data read leaves the count unchanged. The read returns the older byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Queue can take a byte |
| line_err | input | 3 | Overrun, framing and parity flags, live |
| tx_strobe | output | 1 | One-cycle pulse per transmitted byte |
| tx_data | output | 8 | Byte being transmitted |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational, so the bench samples `bus_rdata` one nanosecond after driving the request at a falling edge. This happens before the rising edge that commits the access. Every state effect appears after that rising edge: a pop, push, queue clear, pending-flag change or control/transmit store. These effects are checked at the next falling edge, one cycle after the stimulus. The same applies to `tx_strobe`, `tx_data` and `irq`, which all come from registers. `tx_strobe` is checked high at that falling edge and low one cycle later, which pins the pulse to a single cycle.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int ERR_W  = 3;

    // Control word bit positions
    localparam int CTL_TX_CLR = 0;
    localparam int CTL_RX_CLR = 1;
    localparam int CTL_IRQ_EN = 4;

    typedef enum logic [1:0] {
        W_RXD  = 2'd0,
        W_TXD  = 2'd1,
        W_STAT = 2'd2,
        W_CTRL = 2'd3
    } word_e;

    // Status word layout, MSB first
    typedef struct packed {
        logic [WORD_W-9:0] rsvd;
        logic              parity_err;
        logic              frame_err;
        logic              overrun_err;
        logic              pend;
        logic              tx_full;
        logic              tx_empty;
        logic              rx_full;
        logic              rx_avail;
    } stat_t;

    // One-hot decoded bus access
    typedef struct packed {
        logic rd_rxd;
        logic rd_stat;
        logic wr_txd;
        logic wr_stat;
        logic wr_ctrl;
    } acc_t;

    function automatic acc_t decode_acc(logic valid, logic write, word_e w);
        acc_t a;
        a.rd_rxd  = valid && !write && (w == W_RXD);
        a.rd_stat = valid && !write && (w == W_STAT);
        a.wr_txd  = valid &&  write && (w == W_TXD);
        a.wr_stat = valid &&  write && (w == W_STAT);
        a.wr_ctrl = valid &&  write && (w == W_CTRL);
        return a;
    endfunction

    function automatic stat_t pack_status(logic avail, logic full, logic pend,
                                          logic [ERR_W-1:0] err);
        stat_t s;
        s.rsvd        = '0;
        s.parity_err  = err[2];
        s.frame_err   = err[1];
        s.overrun_err = err[0];
        s.pend        = pend;
        s.tx_full     = 1'b0;
        s.tx_empty    = 1'b1;
        s.rx_full     = full;
        s.rx_avail    = avail;
        return s;
    endfunction

endpackage

// File: rtl/uart_fe_rxq.sv
module uart_fe_rxq #(
    parameter int DEPTH  = 8,
    parameter int BYTE_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [BYTE_W-1:0]            in_data,
    output logic                         in_ready,
    input  logic                         pop,
    input  logic                         clr,
    output logic [BYTE_W-1:0]            head,
    output logic                         avail,
    output logic                         full,
    output logic                         avail_next
);
    // DEPTH must be a power of two: read position is derived by modular subtraction
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [BYTE_W-1:0] slot [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_d;
    logic              push;
    logic              take;

    assign full     = (cnt_q == CNT_MAX);
    assign avail    = (cnt_q != '0);
    assign in_ready = !full;
    assign push     = in_valid && !full && !clr;
    assign take     = pop && avail && !clr;
    assign rd_ptr   = wr_ptr - PTR_W'(cnt_q);
    assign head     = slot[rd_ptr];

    always_comb begin
        if (clr) begin
            cnt_d = '0;
        end else begin
            unique case ({push, take})
                2'b10:   cnt_d = cnt_q + 1'b1;
                2'b01:   cnt_d = cnt_q - 1'b1;
                default: cnt_d = cnt_q;
            endcase
        end
    end

    assign avail_next = (cnt_d != '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (push) wr_ptr <= wr_ptr + 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[g] <= '0;
            end else if (push && (wr_ptr == PTR_W'(g))) begin
                slot[g] <= in_data;
            end
        end
    end

    // R4: count never exceeds capacity
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_MAX);

    // R4: full queue stays full when a byte is offered and nothing leaves
    assert_full_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (full && in_valid && !pop && !clr) |=> full);

    // R3: pop of a nonempty queue without arrival lowers the count by one
    assert_pop_dec_R3: assert property (@(posedge clk) disable iff (rst)
        (pop && avail && !in_valid && !clr) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R3: pop of an empty queue leaves it empty
    assert_empty_pop_R3: assert property (@(posedge clk) disable iff (rst)
        (pop && !avail && !in_valid && !clr) |=> !avail);

    // R13: simultaneous accept and pop keep the count
    assert_push_pop_R13: assert property (@(posedge clk) disable iff (rst)
        (pop && avail && in_valid && !full && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/uart_fe_regs.sv
module uart_fe_regs
    import uart_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  acc_t              acc,
    input  logic [WORD_W-1:0] wdata,
    input  logic              avail_next,
    output logic [WORD_W-1:0] ctrl_q,
    output logic [WORD_W-1:0] tx_q,
    output logic              pend_q,
    output logic              tx_strobe,
    output logic              irq
);
    logic pend_d;

    // Pending: set by data left in the queue or a transmit write; a status read clears
    assign pend_d = acc.wr_txd || avail_next || (pend_q && !acc.rd_stat);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            tx_q      <= '0;
            pend_q    <= 1'b0;
            tx_strobe <= 1'b0;
            irq       <= 1'b0;
        end else begin
            if (acc.wr_ctrl) ctrl_q <= wdata;
            if (acc.wr_txd)  tx_q   <= wdata;
            tx_strobe <= acc.wr_txd;
            pend_q    <= pend_d;
            irq       <= pend_d && (acc.wr_ctrl ? wdata[CTL_IRQ_EN] : ctrl_q[CTL_IRQ_EN]);
        end
    end

    // R7: a transmit write leaves the pending flag set
    assert_pend_on_tx_R7: assert property (@(posedge clk) disable iff (rst)
        acc.wr_txd |=> pend_q);

    // R11: strobe follows a transmit write with the written low byte
    assert_tx_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        acc.wr_txd |=> (tx_strobe && (tx_q[BYTE_W-1:0] == $past(wdata[BYTE_W-1:0]))));

    // R11: no strobe without a preceding transmit write
    assert_tx_no_spur_R11: assert property (@(posedge clk) disable iff (rst)
        !acc.wr_txd |=> !tx_strobe);

    // R9: interrupt only with enable set
    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ctrl_q[CTL_IRQ_EN] && pend_q));

endmodule

// File: rtl/uart_fe.sv
module uart_fe
    import uart_fe_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    input  logic [2:0]        line_err,
    output logic              tx_strobe,
    output logic [7:0]        tx_data
,
    output logic              irq
);
    word_e             word;
    acc_t              acc;
    logic              rx_clr;
    logic [BYTE_W-1:0] head;
    logic              avail;
    logic              full;
    logic              avail_next;
    logic [WORD_W-1:0] ctrl_q;
    logic [WORD_W-1:0] tx_q;
    logic              pend_q;
    stat_t             stat;

    assign word   = word_e'(bus_addr[3:2]);
    assign acc    = decode_acc(bus_valid, bus_write, word);
    assign rx_clr = acc.wr_ctrl && bus_wdata[CTL_RX_CLR];

    uart_fe_rxq #(
        .DEPTH  (DEPTH),
        .BYTE_W (BYTE_W)
    ) u_rxq (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (rx_valid),
        .in_data    (rx_data),
        .in_ready   (rx_ready),
        .pop        (acc.rd_rxd),
        .clr        (rx_clr),
        .head       (head),
        .avail      (avail),
        .full       (full),
        .avail_next (avail_next)
    );

    uart_fe_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .acc        (acc),
        .wdata      (bus_wdata),
        .avail_next (avail_next),
        .ctrl_q     (ctrl_q),
        .tx_q       (tx_q),
        .pend_q     (pend_q),
        .tx_strobe  (tx_strobe),
        .irq        (irq)
    );

    assign tx_data = tx_q[BYTE_W-1:0];
    assign stat    = pack_status(avail, full, pend_q, line_err);

    always_comb begin
        unique case (word)
            W_RXD:   bus_rdata = {{(WORD_W-BYTE_W){1'b0}}, head};
            W_TXD:   bus_rdata = tx_q;
            W_STAT:  bus_rdata = stat;
            W_CTRL:  bus_rdata = ctrl_q;
            default: bus_rdata = '0;
        endcase
    end

    // R6: a receive clear empties the queue
    assert_rx_clear_R6: assert property (@(posedge clk) disable iff (rst)
        rx_clr |=> (!avail && rx_ready));

    // R8: status read with empty queue and no arrival drops the pending flag
    assert_pend_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (acc.rd_stat && !avail && !rx_valid) |=> !pend_q);

    // R7: data left in the queue keeps the pending flag set
    assert_pend_on_data_R7: assert property (@(posedge clk) disable iff (rst)
        avail |-> pend_q);

    // R10: a status write touches neither control nor transmit storage
    assert_stat_wr_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        acc.wr_stat |=> ($stable(ctrl_q) && $stable(tx_q)));

endmodule

// File: tb/tb_uart_fe.sv
`timescale 1ns/1ps
module tb_uart_fe;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_valid, bus_write;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        rx_valid, rx_ready;
    logic [7:0]  rx_data;
    logic [2:0]  line_err;
    logic        tx_strobe, irq;
    logic [7:0]  tx_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    uart_fe dut (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .line_err(line_err), .tx_strobe(tx_strobe), .tx_data(tx_data), .irq(irq)
    );

    localparam logic [1:0] RXD = 2'd0, TXD = 2'd1, STA = 2'd2, CTL = 2'd3;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] stat_exp(int cnt, bit pend, logic [2:0] err);
        return {24'd0, err, pend, 1'b0, 1'b1, (cnt == 8), (cnt != 0)};
    endfunction

    task automatic rd(input logic [1:0] w, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = {w, 2'b00};
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 0;
    endtask

    task automatic wr(input logic [1:0] w, input logic [31:0] v);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = {w, 2'b00}; bus_wdata = v;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1; rx_data = b;
        @(negedge clk);
        rx_valid = 0;
    endtask

    task automatic peek(input logic [1:0] w, output logic [31:0] d);
        bus_addr = {w, 2'b00};
        #1 d = bus_rdata;
    endtask

    task automatic do_reset();
        logic [31:0] d;
        rst = 1; bus_valid = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0;
        rx_valid = 0; rx_data = 0; line_err = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        peek(STA, d); chk("R12 status", d, 32'h4);
        peek(CTL, d); chk("R12 ctrl", d, 0);
        peek(TXD, d); chk("R12 tx", d, 0);
        chk("R12 irq", irq, 0);
        chk("R12 rx_ready", rx_ready, 1);
    endtask

    task automatic t_decode();
        logic [31:0] d;
        wr(CTL, 32'hA5A5_0000);
        rd(CTL, d); chk("R1 ctrl readback", d, 32'hA5A5_0000);
        wr(TXD, 32'h1234_5678);
        rd(TXD, d); chk("R1 tx readback", d, 32'h1234_5678);
        rd(STA, d);
        rd(STA, d); chk("R1 status word", d, stat_exp(0, 0, 0));
        wr(CTL, 0);
    endtask

    task automatic t_order_wrap();
        logic [31:0] d;
        for (int i = 0; i < 5; i++) push(8'h10 + 8'(i));
        rd(STA, d); chk("R5 status 5 held", d, stat_exp(5, 1, 0));
        for (int i = 0; i < 5; i++) begin
            rd(RXD, d); chk("R2 order", d, 32'h10 + i);
        end
        for (int i = 0; i < 8; i++) push(8'hC0 + 8'(i));
        rd(STA, d); chk("R5 status full", d, stat_exp(8, 1, 0));
        chk("R4 ready low when full", rx_ready, 0);
        push(8'hEE);
        for (int i = 0; i < 8; i++) begin
            rd(RXD, d); chk("R2 wrap order", d, 32'hC0 + i);
        end
        rd(STA, d); chk("R4 dropped byte absent", d, stat_exp(0, 1, 0));
        chk("R4 ready back", rx_ready, 1);
    endtask

    task automatic t_empty_read();
        logic [31:0] d;
        rd(RXD, d);
        rd(STA, d); chk("R3 empty read no change", d, stat_exp(0, 0, 0));
        push(8'h5A); push(8'h6B);
        rd(RXD, d); chk("R3 pop value", d, 32'h5A);
        rd(STA, d); chk("R3 one left", d, stat_exp(1, 1, 0));
        rd(RXD, d); chk("R3 second pop", d, 32'h6B);
    endtask

    task automatic t_rx_reset();
        logic [31:0] d;
        push(8'h01); push(8'h02); push(8'h03);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = {CTL, 2'b00}; bus_wdata = 32'h2;
        rx_valid = 1; rx_data = 8'h77;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; rx_valid = 0;
        peek(STA, d); chk("R6 queue emptied", d[1:0], 0);
        rd(CTL, d); chk("R6 ctrl kept", d, 32'h2);
        push(8'h99);
        rd(RXD, d); chk("R6 fresh byte after clear", d, 32'h99);
        wr(CTL, 0);
        rd(STA, d);
    endtask

    task automatic t_pend();
        logic [31:0] d;
        wr(TXD, 32'h41);
        peek(STA, d); chk("R7 pend after tx write", d[4], 1);
        rd(STA, d); chk("R8 returned with flag", d[4], 1);
        peek(STA, d); chk("R8 cleared by read", d[4], 0);
        push(8'h33);
        rd(STA, d);
        peek(STA, d); chk("R8 kept while nonempty", d[4], 1);
        rd(RXD, d);
        peek(STA, d); chk("R7 stays until status read", d[4], 1);
        rd(STA, d);
        peek(STA, d); chk("R8 cleared when empty", d[4], 0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(TXD, 32'h20);
        chk("R9 no irq with enable off", irq, 0);
        wr(CTL, 32'h10);
        chk("R9 irq when enabled and pending", irq, 1);
        rd(STA, d);
        chk("R9 irq drops with flag", irq, 0);
        push(8'h44);
        chk("R9 irq on receive", irq, 1);
        wr(CTL, 0);
        chk("R9 irq off with enable cleared", irq, 0);
        rd(RXD, d); rd(STA, d);
    endtask

    task automatic t_stat_write();
        logic [31:0] d;
        push(8'h55);
        wr(STA, 32'hFFFF_FFFF);
        rd(STA, d); chk("R10 status unaffected", d, stat_exp(1, 1, 0));
        rd(RXD, d); chk("R10 queue intact", d, 32'h55);
        rd(STA, d);
        wr(STA, 32'h0);
        line_err = 3'b101;
        peek(STA, d); chk("R5 error flags", d, stat_exp(0, 0, 3'b101));
        line_err = 0;
    endtask

    task automatic t_tx();
        logic [31:0] d;
        @(negedge clk);
        chk("R11 idle strobe", tx_strobe, 0);
        wr(TXD, 32'hDEAD_BE9C);
        chk("R11 strobe high", tx_strobe, 1);
        chk("R11 tx byte", tx_data, 8'h9C);
        @(negedge clk);
        chk("R11 strobe single cycle", tx_strobe, 0);
        rd(TXD, d); chk("R11 full value stored", d, 32'hDEAD_BE9C);
        rd(STA, d);
    endtask

    task automatic t_push_pop();
        logic [31:0] d;
        push(8'hA1);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = {RXD, 2'b00};
        rx_valid = 1; rx_data = 8'hB2;
        #1 d = bus_rdata;
        chk("R13 older byte returned", d, 32'hA1);
        @(negedge clk);
        bus_valid = 0; rx_valid = 0;
        peek(STA, d); chk("R13 count unchanged", d[1:0], 2'b01);
        rd(RXD, d); chk("R13 newer byte next", d, 32'hB2);
        peek(STA, d); chk("R13 now empty", d[0], 0);
    endtask

    initial begin
        do_reset();
        t_decode();
        t_order_wrap();
        rd(STA, bus_wdata);
        t_empty_read();
        rd(STA, bus_wdata);
        t_rx_reset();
        t_pend();
        t_irq();
        t_stat_write();
        t_tx();
        t_push_pop();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule